// File: doc/BRIEF.md
# Two-Sensor Tank Pump Controller

This block runs a water pump from two binary level probes mounted in a tank. One probe sits near the bottom and one near the top. The pump starts only once the tank has drained to empty. It then keeps running through mid-level and stops only when both probes are wet. Because filling starts and stops at different levels, the pump does not chatter while the level sits between the two probes.

A reading where the top probe is wet and the bottom probe is dry cannot occur in a working tank. The controller treats it as a fault: it stops the pump, raises a fault flag and stays in that state until both probes read dry. After that it returns to idle.

The four-state machine is Moore style. The pump enable, the fault flag and the two-bit state code are all decoded from the state register, so a sensor change inside a cycle never reaches the outputs before the next clock edge. The sensor inputs are expected to be synchronised and debounced before they reach this block.

Top module: `tank_pump_ctrl`

## Requirements
- R1: Driving `arst_ni` low forces `mode_o` to 00, `pump_en_o` to 0 and `fault_o` to 0 at once, without waiting for a clock edge.
- R2: `lvl_i[0]` is the bottom probe and `lvl_i[1]` is the top probe (1 = wet). `mode_o` codes are 00 idle, 01 filling, 10 full and 11 fault. Every state change happens at the rising clock edge after the sensor value is applied.
- R3: In idle, `lvl_i` = 00 moves to filling and 10 moves to fault. The values 01 and 11 keep the state in idle.
- R4: In filling, 00 and 01 keep the state in filling, 11 moves to full and 10 moves to fault.
- R5: In full, 01 and 11 keep the state in full, 00 moves to filling and 10 moves to fault.
- R6: In fault, 01, 10 and 11 keep the state in fault. Only 00 moves it to idle.
- R7: `pump_en_o` is 1 exactly when the state is filling.
- R8: `fault_o` is 1 exactly when the state is fault.
- R9: A change of `lvl_i` between clock edges leaves `pump_en_o`, `fault_o` and `mode_o` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| arst_ni | input | 1 | Asynchronous reset, active low |
| lvl_i | input | 2 | Probe readings {top, bottom}, 1 = wet |
| pump_en_o | output | 1 | Pump enable, 1 = run |
| fault_o | output | 1 | Impossible probe reading latched |
| mode_o | output | 2 | Current state code |

## Verification
Directed sequences take the tank through a full cycle: empty, mid-level, full, draining through mid-level and empty again. This separates true hysteresis from a controller that simply follows the probes, because the pump must stay on at mid-level while filling and stay off at mid-level while draining. Each state is also given the impossible 10 pattern, and the fault state is given 01 and 11, which shows that the fault clears only on a fully dry reading. A long random stream of probe values, checked against a reference next-state function, reaches every state and input pair many times. Mid-cycle input changes and a reset asserted away from the clock edge tell registered outputs apart from combinational ones and an asynchronous reset apart from a synchronous one.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_IDLE  = 2'b00,
      MODE_FILL  = 2'b01,
      MODE_FULL  = 2'b10,
      MODE_FAULT = 2'b11
   } mode_e;

   typedef enum logic [1:0] {
      LVL_DRY,
      LVL_MID,
      LVL_TOP,
      LVL_BAD
   } lvl_class_e;

endpackage

// File: rtl/tpc_level_decode.sv
module tpc_level_decode
   import tpc_pkg::*;
#(
   parameter int SENSE_W  = 2,
   parameter int LOW_BIT  = 0,
   parameter int HIGH_BIT = 1
) (
   input  logic [SENSE_W-1:0] lvl_i,
   output lvl_class_e         cls_o
);

   logic low_wet;
   logic high_wet;

   assign low_wet  = lvl_i[LOW_BIT];
   assign high_wet = lvl_i[HIGH_BIT];

   always_comb begin
      unique case ({high_wet, low_wet})
         2'b00:   cls_o = LVL_DRY;
         2'b01:   cls_o = LVL_MID;
         2'b11:   cls_o = LVL_TOP;
         default: cls_o = LVL_BAD;
      endcase
   end

endmodule

// File: rtl/tpc_next_state.sv
module tpc_next_state
   import tpc_pkg::*;
(
   input  mode_e      cur_i,
   input  lvl_class_e cls_i,
   output mode_e      nxt_o
);

   always_comb begin
      nxt_o = cur_i;
      case (cur_i)
         MODE_IDLE: begin
            if (cls_i == LVL_BAD)      nxt_o = MODE_FAULT;
            else if (cls_i == LVL_DRY) nxt_o = MODE_FILL;
         end
         MODE_FILL: begin
            if (cls_i == LVL_BAD)      nxt_o = MODE_FAULT;
            else if (cls_i == LVL_TOP) nxt_o = MODE_FULL;
         end
         MODE_FULL: begin
            if (cls_i == LVL_BAD)      nxt_o = MODE_FAULT;
            else if (cls_i == LVL_DRY) nxt_o = MODE_FILL;
         end
         MODE_FAULT: begin
            if (cls_i == LVL_DRY)      nxt_o = MODE_IDLE;
         end
         default: nxt_o = MODE_IDLE;
      endcase
   end

endmodule

// File: rtl/tpc_state_reg.sv
module tpc_state_reg
   import tpc_pkg::*;
(
   input  logic  clk_i,
   input  logic  arst_ni,
   input  mode_e nxt_i,
   output mode_e cur_o
);

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) cur_o <= MODE_IDLE;
      else          cur_o <= nxt_i;
   end

endmodule

// File: rtl/tank_pump_ctrl.sv
module tank_pump_ctrl
   import tpc_pkg::*;
#(
   parameter int SENSE_W  = 2,
   parameter int LOW_BIT  = 0,
   parameter int HIGH_BIT = 1
) (
   input  logic              clk_i,
   input  logic              arst_ni,
   input  logic [SENSE_W-1:0] lvl_i,
   output logic              pump_en_o,
   output logic              fault_o,
   output logic [MODE_W-1:0] mode_o
);

   generate
      if (SENSE_W != 2) begin : g_bad_width
         $error("tank_pump_ctrl: SENSE_W must be 2");
      end
      if (LOW_BIT == HIGH_BIT || LOW_BIT >= SENSE_W || HIGH_BIT >= SENSE_W)
      begin : g_bad_bits
         $error("tank_pump_ctrl: probe bit positions invalid");
      end
   endgenerate

   lvl_class_e cls;
   mode_e      cur;
   mode_e      nxt;

   tpc_level_decode #(
      .SENSE_W  (SENSE_W),
      .LOW_BIT  (LOW_BIT),
      .HIGH_BIT (HIGH_BIT)
   ) u_decode (
      .lvl_i (lvl_i),
      .cls_o (cls)
   );

   tpc_next_state u_next (
      .cur_i (cur),
      .cls_i (cls),
      .nxt_o (nxt)
   );

   tpc_state_reg u_reg (
      .clk_i   (clk_i),
      .arst_ni (arst_ni),
      .nxt_i   (nxt),
      .cur_o   (cur)
   );

   // Moore outputs: decoded from the register only
   assign mode_o    = cur;
   assign pump_en_o = (cur == MODE_FILL);
   assign fault_o   = (cur == MODE_FAULT);

endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
   parameter int SENSE_W = 2
) (
   input logic               clk_i,
   input logic               arst_ni,
   input logic [SENSE_W-1:0] lvl_i,
   input logic               pump_en_o,
   input logic               fault_o,
   input logic [1:0]         mode_o
);

   p_bad_to_fault_r6: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (lvl_i == 2'b10) |=> (mode_o == 2'b11));

   p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (mode_o == 2'b00 && lvl_i[0]) |=> (mode_o == 2'b00));

   p_fill_stop_r4: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (mode_o == 2'b01 && lvl_i == 2'b11) |=> (mode_o == 2'b10));

   p_full_hold_r5: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (mode_o == 2'b10 && lvl_i[0]) |=> (mode_o == 2'b10));

   p_fault_clear_r6: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (mode_o == 2'b11 && lvl_i == 2'b00) |=> (mode_o == 2'b00));

   p_pump_match_r7: assert property (@(posedge clk_i) disable iff (!arst_ni)
      pump_en_o == (mode_o == 2'b01));

   p_flag_match_r8: assert property (@(posedge clk_i) disable iff (!arst_ni)
      fault_o == (mode_o == 2'b11));

endmodule

bind tank_pump_ctrl tpc_checker #(.SENSE_W(SENSE_W)) u_chk (
   .clk_i     (clk_i),
   .arst_ni   (arst_ni),
   .lvl_i     (lvl_i),
   .pump_en_o (pump_en_o),
   .fault_o   (fault_o),
   .mode_o    (mode_o)
);

// File: tb/tank_pump_ctrl_tb_top.sv
module tank_pump_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       arst_n = 1'b0;
   logic [1:0] lvl = 2'b00;
   logic       pump;
   logic       flt;
   logic [1:0] mode;

   int total = 0;
   int bad   = 0;
   logic [1:0] exp_mode = 2'b00;

   always #5 clk = ~clk;

   tank_pump_ctrl dut_i (
      .clk_i     (clk),
      .arst_ni   (arst_n),
      .lvl_i     (lvl),
      .pump_en_o (pump),
      .fault_o   (flt),
      .mode_o    (mode)
   );

   function automatic logic [1:0] ref_next(logic [1:0] m, logic [1:0] s);
      case (m)
         2'b00: return (s == 2'b10) ? 2'b11 : (s == 2'b00) ? 2'b01 : 2'b00;
         2'b01: return (s == 2'b10) ? 2'b11 : (s == 2'b11) ? 2'b10 : 2'b01;
         2'b10: return (s == 2'b10) ? 2'b11 : (s == 2'b00) ? 2'b01 : 2'b10;
         default: return (s == 2'b00) ? 2'b00 : 2'b11;
      endcase
   endfunction

   function automatic string tag_of(logic [1:0] m);
      case (m)
         2'b00: return "R3";
         2'b01: return "R4";
         2'b10: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_all(string tag);
      chk(tag, 32'(mode), 32'(exp_mode));
      chk("R7", 32'(pump), 32'(exp_mode == 2'b01));
      chk("R8", 32'(flt), 32'(exp_mode == 2'b11));
   endtask

   // apply s before the edge, check just after it
   task automatic step(logic [1:0] s);
      string t;
      @(negedge clk);
      lvl = s;
      t = tag_of(exp_mode);
      @(posedge clk);
      exp_mode = ref_next(exp_mode, s);
      #1;
      chk_all(t);
   endtask

   initial begin : watchdog
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd2024);
      repeat (3) @(posedge clk);
      #1;
      chk("R1", 32'(mode), 0);
      chk("R1", 32'(pump), 0);
      chk("R1", 32'(flt), 0);
      @(negedge clk);
      arst_n = 1'b1;
      lvl = 2'b01;

      // R2 R3: idle holds on 01/11, empty starts filling
      step(2'b01); chk("R2", 32'(mode), 0);
      step(2'b11); chk("R3", 32'(mode), 0);
      step(2'b00); chk("R2", 32'(mode), 1);
      // R4: hold through mid, stop on full
      step(2'b01); step(2'b00); step(2'b01);
      step(2'b11); chk("R2", 32'(mode), 2);
      // R5: drain through mid with pump off
      step(2'b01); chk("R5", 32'(pump), 0);
      step(2'b11);
      step(2'b00); chk("R5", 32'(mode), 1);
      // R9: mid-cycle change in filling does not reach outputs
      @(negedge clk); lvl = 2'b01;
      @(posedge clk); #1;
      lvl = 2'b11; #2;
      chk("R9", 32'(mode), 1);
      chk("R9", 32'(pump), 1);
      lvl = 2'b10; #1;
      chk("R9", 32'(flt), 0);
      lvl = 2'b01;
      // R6: bad pattern from filling, hold on 01/11/10, clear on 00
      step(2'b10); chk("R2", 32'(mode), 3);
      step(2'b01); step(2'b11); step(2'b10);
      chk("R6", 32'(flt), 1);
      step(2'b00); chk("R6", 32'(mode), 0);
      // bad pattern from idle and from full
      step(2'b10); step(2'b00);
      step(2'b00); step(2'b11);
      step(2'b10); chk("R5", 32'(mode), 3);
      step(2'b00);

      // R1: asynchronous reset away from the edge
      step(2'b00);
      @(negedge clk); #2;
      arst_n = 1'b0; #1;
      chk("R1", 32'(mode), 0);
      chk("R1", 32'(pump), 0);
      exp_mode = 2'b00;
      @(negedge clk);
      lvl = 2'b01;
      arst_n = 1'b1;

      // random stream
      for (int i = 0; i < 400; i++) begin
         logic [1:0] s;
         s = 2'($urandom() % 4);
         step(s);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule